// File: doc/BRIEF.md
# Transaction-to-Flit Segmenter

This block takes one transaction descriptor at a time. A descriptor holds a payload byte count and the byte address of the first chunk. The block splits it into a stream of flit descriptors. Each flit descriptor gives its position in the transaction, the bytes it covers, its own byte address and a flag that marks the final flit. The block moves no payload data. It only works out how the payload is cut up and where each piece lands.

The flit size is a runtime setting. It must be a power of two, and it is normally set equal to the memory burst size or to a multiple of it. The setting is captured when a descriptor is accepted, so it can change between transactions without disturbing one in flight. Descriptors enter through a valid/ready handshake. Flits leave through a valid/ready stream that the consumer can stall for any number of cycles.

A descriptor with no bytes, or one that arrives while the flit size is zero, is taken in and produces nothing. The next descriptor can follow in the very next cycle.

Top module: `flit_segmenter`

## Requirements
- R1: A descriptor of N bytes with flit size S (S a nonzero power of two) yields floor(N/S) flits, plus one more flit when N mod S is nonzero, and no others.
- R2: Every flit except the final one reports exactly S bytes. The final flit reports N mod S when that is nonzero, and S otherwise.
- R3: The last flag is 1 on the final flit of a transaction and 0 on every other flit.
- R4: Flit i reports address base + i*S, truncated to 32 bits, so addresses wrap past 0xFFFF_FFFF.
- R5: Flit indices run 0, 1, 2, … up to the flit count minus 1, in order, with none skipped or repeated.
- R6: A descriptor with N = 0, or one accepted while the flit size input is 0, is consumed in its handshake cycle, produces no flit, and leaves in_ready high.
- R7: in_ready is low from the cycle after a descriptor with work is accepted until the final flit has been handed off. It is high again in the cycle after that handoff, and it is never high while out_valid is high.
- R8: While out_valid is high and out_ready is low, out_valid stays high and out_index, out_bytes, out_addr and out_last hold their values.
- R9: The flit size is sampled when the descriptor is accepted. Changing cfg_flit_bytes during a transaction has no effect on that transaction's flits.
- R10: The first flit is offered in the cycle after acceptance. With out_ready held high, a transaction of K flits is handed off in K consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_flit_bytes | input | 32 | Flit size in bytes, a power of two, or 0 to discard descriptors |
| in_valid | input | 1 | Descriptor offered |
| in_ready | output | 1 | Segmenter can take a descriptor |
| in_bytes | input | 32 | Payload byte count of the descriptor |
| in_addr | input | 32 | Byte address of the first chunk |
| out_valid | output | 1 | Flit descriptor offered |
| out_ready | input | 1 | Consumer takes the offered flit |
| out_index | output | 32 | Position of the flit within its transaction |
| out_bytes | output | 32 | Bytes covered by the flit |
| out_addr | output | 32 | Byte address of the flit |
| out_last | output | 1 | Final flit of the transaction |

## Verification
The assertions check on every cycle the properties that hold locally:
- offered flits stay frozen under stall;
- the address advances by exactly one flit size per handoff;
- the index stays within the transaction;
- the input and output sides are never open at once;
- the block goes idle right after the final handoff;
- a discarded descriptor leaves the block idle.

The assertions cannot judge whether the totals are right, since those depend on the descriptor as a whole. That is left to the bench scenarios: the flit count, the tail size on exact and inexact multiples, wrap of the address past the top of the space, indifference to a mid-transaction change of flit size, and back-to-back throughput.

// File: rtl/seg_pkg.sv
package seg_pkg;

  parameter int unsigned SEG_LEN_W   = 32;
  parameter int unsigned SEG_ADDR_W  = 32;
  parameter int unsigned SEG_SHIFT_W = $clog2(SEG_LEN_W);

  // Plan produced at acceptance, held for the life of a transaction.
  typedef struct packed {
    logic [SEG_LEN_W-1:0]  last_idx;  // flit count minus one
    logic [SEG_LEN_W-1:0]  tail;      // bytes in the final flit
    logic [SEG_LEN_W-1:0]  step;      // flit size in bytes
    logic [SEG_ADDR_W-1:0] base;      // address of flit 0
  } seg_plan_t;

  // Position of the highest set bit; the flit size is a power of two.
  function automatic logic [SEG_SHIFT_W-1:0] size_shift(input logic [SEG_LEN_W-1:0] sz);
    logic [SEG_SHIFT_W-1:0] sh;
    sh = '0;
    for (int b = 0; b < SEG_LEN_W; b++) begin
      if (sz[b]) sh = SEG_SHIFT_W'(b);
    end
    return sh;
  endfunction

  // Bytes left over after whole flits.
  function automatic logic [SEG_LEN_W-1:0] spill_bytes(input logic [SEG_LEN_W-1:0] nb,
                                                       input logic [SEG_LEN_W-1:0] sz);
    return nb & (sz - SEG_LEN_W'(1));
  endfunction

  // Whole flits plus one if there is a spill.
  function automatic logic [SEG_LEN_W-1:0] flit_total(input logic [SEG_LEN_W-1:0] nb,
                                                      input logic [SEG_LEN_W-1:0] sz);
    logic [SEG_LEN_W-1:0] whole;
    whole = nb >> size_shift(sz);
    return whole + ((spill_bytes(nb, sz) != '0) ? SEG_LEN_W'(1) : SEG_LEN_W'(0));
  endfunction

  // Size of the final flit: the spill, or a full flit on an exact multiple.
  function automatic logic [SEG_LEN_W-1:0] tail_bytes(input logic [SEG_LEN_W-1:0] nb,
                                                      input logic [SEG_LEN_W-1:0] sz);
    logic [SEG_LEN_W-1:0] sp;
    sp = spill_bytes(nb, sz);
    return (sp != '0) ? sp : sz;
  endfunction

endpackage

// File: rtl/seg_intake.sv
module seg_intake
  import seg_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic                  idle,
  input  logic [SEG_LEN_W-1:0]  nbytes,
  input  logic [SEG_ADDR_W-1:0] base_addr,
  input  logic [SEG_LEN_W-1:0]  flit_size,
  output seg_plan_t             plan,
  output logic                  take_evt,   // accepted, flits to follow
  output logic                  skip_evt    // accepted, nothing to emit
);

  logic hs_evt;
  logic empty_job;

  assign hs_evt    = in_valid && idle;
  assign empty_job = (nbytes == '0) || (flit_size == '0);
  assign take_evt  = hs_evt && !empty_job;
  assign skip_evt  = hs_evt && empty_job;

  always_comb begin
    plan.last_idx = flit_total(nbytes, flit_size) - SEG_LEN_W'(1);
    plan.tail     = tail_bytes(nbytes, flit_size);
    plan.step     = flit_size;
    plan.base     = base_addr;
  end

  // R6: an empty descriptor leaves the block idle for the next one.
  assert_skip_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    skip_evt |=> idle);

  // R10: accepted work starts being offered in the next cycle.
  assert_take_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    take_evt |=> !idle);

endmodule

// File: rtl/seg_walker.sv
module seg_walker
  import seg_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  seg_plan_t             plan,
  input  logic                  take_evt,
  input  logic                  out_ready,
  output logic                  active,
  output logic [SEG_LEN_W-1:0]  idx,
  output logic [SEG_ADDR_W-1:0] addr,
  output logic [SEG_LEN_W-1:0]  step_q,
  output logic [SEG_LEN_W-1:0]  tail_q,
  output logic                  is_last,
  output logic                  handoff_evt,
  output logic                  finish_evt
);

  logic [SEG_LEN_W-1:0] last_idx_q;

  assign is_last     = active && (idx == last_idx_q);
  assign handoff_evt = active && out_ready;
  assign finish_evt  = handoff_evt && is_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active     <= 1'b0;
      idx        <= '0;
      addr       <= '0;
      step_q     <= '0;
      tail_q     <= '0;
      last_idx_q <= '0;
    end else if (take_evt) begin
      active     <= 1'b1;
      idx        <= '0;
      addr       <= plan.base;
      step_q     <= plan.step;
      tail_q     <= plan.tail;
      last_idx_q <= plan.last_idx;
    end else if (handoff_evt) begin
      if (is_last) begin
        active <= 1'b0;
      end else begin
        idx  <= idx + SEG_LEN_W'(1);
        addr <= addr + SEG_ADDR_W'(step_q);
      end
    end
  end

  // R4: each non-final handoff moves the address by one flit size.
  assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (handoff_evt && !is_last) |=> (addr == $past(addr) + SEG_ADDR_W'($past(step_q))));

  // R5: index never runs past the final flit.
  assert_idx_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (idx <= last_idx_q));

  // R5: index advances by one per non-final handoff.
  assert_idx_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (handoff_evt && !is_last) |=> (idx == $past(idx) + SEG_LEN_W'(1)));

  // R7: after the final handoff the walker is idle.
  assert_finish_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    finish_evt |=> !active);

endmodule

// File: rtl/seg_emit.sv
module seg_emit
  import seg_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  active,
  input  logic [SEG_LEN_W-1:0]  idx,
  input  logic [SEG_ADDR_W-1:0] addr,
  input  logic [SEG_LEN_W-1:0]  step_q,
  input  logic [SEG_LEN_W-1:0]  tail_q,
  input  logic                  is_last,
  output logic                  out_valid,
  output logic [SEG_LEN_W-1:0]  out_index,
  output logic [SEG_LEN_W-1:0]  out_bytes,
  output logic [SEG_ADDR_W-1:0] out_addr,
  output logic                  out_last
);

  assign out_valid = active;
  assign out_index = idx;
  assign out_addr  = addr;
  assign out_last  = is_last;
  assign out_bytes = is_last ? tail_q : step_q;

  // R2: a non-final flit is always full sized.
  assert_full_body_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_last) |-> (out_bytes == step_q));

  // R2: the final flit never exceeds one flit size and is never empty.
  assert_tail_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_last) |-> ((out_bytes <= step_q) && (out_bytes != '0)));

endmodule

// File: rtl/flit_segmenter.sv
module flit_segmenter
  import seg_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [SEG_LEN_W-1:0]  cfg_flit_bytes,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [SEG_LEN_W-1:0]  in_bytes,
  input  logic [SEG_ADDR_W-1:0] in_addr,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [SEG_LEN_W-1:0]  out_index,
  output logic [SEG_LEN_W-1:0]  out_bytes,
  output logic [SEG_ADDR_W-1:0] out_addr,
  output logic                  out_last
);

  seg_plan_t             plan;
  logic                  take_evt;
  logic                  skip_evt;
  logic                  active;
  logic [SEG_LEN_W-1:0]  idx;
  logic [SEG_ADDR_W-1:0] addr;
  logic [SEG_LEN_W-1:0]  step_q;
  logic [SEG_LEN_W-1:0]  tail_q;
  logic                  is_last;
  logic                  handoff_evt;
  logic                  finish_evt;

  assign in_ready = !active;

  seg_intake u_intake (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .idle      (in_ready),
    .nbytes    (in_bytes),
    .base_addr (in_addr),
    .flit_size (cfg_flit_bytes),
    .plan      (plan),
    .take_evt  (take_evt),
    .skip_evt  (skip_evt)
  );

  seg_walker u_walker (
    .clk         (clk),
    .rst_n       (rst_n),
    .plan        (plan),
    .take_evt    (take_evt),
    .out_ready   (out_ready),
    .active      (active),
    .idx         (idx),
    .addr        (addr),
    .step_q      (step_q),
    .tail_q      (tail_q),
    .is_last     (is_last),
    .handoff_evt (handoff_evt),
    .finish_evt  (finish_evt)
  );

  seg_emit u_emit (
    .clk       (clk),
    .rst_n     (rst_n),
    .active    (active),
    .idx       (idx),
    .addr      (addr),
    .step_q    (step_q),
    .tail_q    (tail_q),
    .is_last   (is_last),
    .out_valid (out_valid),
    .out_index (out_index),
    .out_bytes (out_bytes),
    .out_addr  (out_addr),
    .out_last  (out_last)
  );

  // R8: a stalled flit stays offered and frozen.
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_index) && $stable(out_bytes)
                                   && $stable(out_addr) && $stable(out_last)));

  // R7: the two sides are never open together.
  assert_one_side_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));

  // R7: once the final flit goes, a new descriptor may enter.
  assert_reopen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> in_ready);

  // R3: a first flit that is also final shows up only on one-flit jobs (index 0).
  assert_last_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_last && (out_index == '0)) |-> (out_bytes <= step_q));

endmodule

// File: tb/sim_flit_segmenter.sv
`timescale 1ns/1ps
module sim_flit_segmenter;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cfg_flit_bytes = 32'd0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_bytes = 32'd0;
  logic [31:0] in_addr = 32'd0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_index;
  logic [31:0] out_bytes;
  logic [31:0] out_addr;
  logic        out_last;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  flit_segmenter u0 (
    .clk(clk), .rst_n(rst_n), .cfg_flit_bytes(cfg_flit_bytes),
    .in_valid(in_valid), .in_ready(in_ready), .in_bytes(in_bytes), .in_addr(in_addr),
    .out_valid(out_valid), .out_ready(out_ready), .out_index(out_index),
    .out_bytes(out_bytes), .out_addr(out_addr), .out_last(out_last)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Offers one descriptor and drains its flits. mode 0: ready always high,
  // mode 1: ready low every third cycle. cfg_late replaces the size after
  // acceptance (R9).
  task automatic run_txn(input longint nb, input longint base, input longint fb,
                         input int mode, input longint cfg_late);
    longint n, rem, esz;
    logic [31:0] eaddr;
    int got, cyc;
    bit rdy, stalled;
    logic [31:0] p_idx, p_bytes, p_addr;
    logic p_last;
    @(negedge clk);
    chk(in_ready == 1'b1, "R7", "in_ready before offer", in_ready, 1);
    in_valid = 1'b1;
    in_bytes = 32'(nb);
    in_addr = 32'(base);
    cfg_flit_bytes = 32'(fb);
    @(negedge clk);
    in_valid = 1'b0;
    cfg_flit_bytes = 32'(cfg_late);
    if (nb == 0 || fb == 0) n = 0;
    else n = nb / fb + ((nb % fb) != 0 ? 1 : 0);
    rem = (fb == 0) ? 0 : nb % fb;
    if (n == 0) begin
      chk(out_valid == 1'b0, "R6", "no flit after empty job", out_valid, 0);
      chk(in_ready == 1'b1, "R6", "in_ready after empty job", in_ready, 1);
      @(negedge clk);
      chk(out_valid == 1'b0, "R6", "still no flit", out_valid, 0);
      return;
    end
    chk(in_ready == 1'b0, "R7", "in_ready while busy", in_ready, 0);
    chk(out_valid == 1'b1, "R10", "first flit next cycle", out_valid, 1);
    got = 0; cyc = 0; stalled = 1'b0;
    p_idx = '0; p_bytes = '0; p_addr = '0; p_last = 1'b0;
    while (got < n && cyc < 5000) begin
      rdy = (mode == 0) ? 1'b1 : ((cyc % 3) != 2);
      out_ready = rdy;
      esz = (got == n - 1 && rem != 0) ? rem : fb;
      eaddr = 32'(base + longint'(got) * fb);
      chk(out_valid == 1'b1, "R1", "flit offered", out_valid, 1);
      chk(out_index == 32'(got), "R5", "index", out_index, got);
      chk(out_bytes == 32'(esz), "R2", "bytes", out_bytes, esz);
      chk(out_addr == eaddr, "R4", "addr", out_addr, eaddr);
      chk(out_last == (got == n - 1), "R3", "last flag", out_last, (got == n - 1));
      if (stalled) begin
        chk(out_addr == p_addr && out_bytes == p_bytes && out_index == p_idx && out_last == p_last,
            "R8", "hold under stall addr", out_addr, p_addr);
      end
      p_idx = out_index; p_bytes = out_bytes; p_addr = out_addr; p_last = out_last;
      stalled = !rdy;
      @(negedge clk);
      if (rdy) got++;
      cyc++;
    end
    out_ready = 1'b0;
    chk(got == n, "R1", "flit count", got, n);
    if (mode == 0) chk(cyc == n, "R10", "cycles for job", cyc, n);
    chk(out_valid == 1'b0, "R1", "no extra flit", out_valid, 0);
    chk(in_ready == 1'b1, "R7", "in_ready after final", in_ready, 1);
  endtask

  task automatic t_reset();
    chk(in_ready == 1'b1, "R7", "reset in_ready", in_ready, 1);
    chk(out_valid == 1'b0, "R1", "reset out_valid", out_valid, 0);
  endtask

  task automatic t_exact();       run_txn(1024, 32'h1000, 256, 0, 256); endtask
  task automatic t_remainder();   run_txn(1000, 32'h2000, 256, 0, 256); endtask
  task automatic t_single();      run_txn(10, 32'h0040, 256, 0, 256); endtask
  task automatic t_zero_bytes();  run_txn(0, 32'h3000, 256, 0, 256); endtask
  task automatic t_zero_size();   run_txn(700, 32'h3000, 0, 0, 0); endtask
  task automatic t_wrap();        run_txn(1100, 32'hFFFF_FF00, 256, 0, 256); endtask
  task automatic t_byte_flits();  run_txn(5, 32'h0000_0007, 1, 0, 1); endtask
  task automatic t_stall();       run_txn(2300, 32'h0001_0000, 512, 1, 512); endtask
  task automatic t_cfg_change();  run_txn(900, 32'h0005_0000, 128, 1, 8); endtask
  task automatic t_big_flit();    run_txn(100, 32'h0000_1F00, 4096, 0, 4096); endtask
  task automatic t_back_to_back();
    run_txn(512, 32'h0000_8000, 256, 0, 256);
    run_txn(0, 32'h0000_9000, 256, 0, 256);
    run_txn(300, 32'h0000_A000, 64, 1, 64);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_exact();
    t_remainder();
    t_single();
    t_zero_bytes();
    t_zero_size();
    t_wrap();
    t_byte_flits();
    t_stall();
    t_cfg_change();
    t_big_flit();
    t_back_to_back();
    repeat (2) @(negedge clk);
    finish_up();
  end

  initial begin
    #(4 * 150000);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    finish_up();
  end

endmodule